// File: doc/BRIEF.md
# Clock Synthesizer Power-Down Sequencer

This block takes a clock synthesizer into and out of its low-power state. The request arrives on an active-low power-down pin with no timing relation to the sequencer clock. The pin level first passes through a synchronizer. After that, every clock group's output-hold control is raised on a falling clock edge, which parks the outputs low. The sequencer then waits until the slow reference outputs report that they have settled low. Only after that does it turn off the oscillator and VCO enables.

When the request is withdrawn, the sequence runs in reverse:

1. The oscillator comes back first.
2. One cycle later the VCOs are enabled.
3. A settle counter of programmable length stands in for PLL lock.
4. The hold controls are dropped, and the clocks run again.

The settle counter runs on the always-on sequencer clock, which keeps ticking while the synthesizer's own clocks are stopped.

The state machine has seven states:

- RUN
- PARK_OUTPUTS (entered when the synchronized request is seen in RUN)
- WAIT_REF_LOW (entered unconditionally one cycle after PARK_OUTPUTS)
- SHUTDOWN (entered when the reference-low indication is high in WAIT_REF_LOW)
- WAKE_OSC (entered when the request is gone in SHUTDOWN)
- SETTLE (entered unconditionally after WAKE_OSC)
- RELEASE (entered when the settle count expires)

RELEASE always returns to RUN. No state leaves either the entry path or the wake path early.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, `osc_en_o` is 1, every bit of `vco_en_o` is 1 and every bit of `hold_o` is 0.
- R2: `pd_n` is sampled through `SYNC_STAGES` rising-edge flops. With the default of 2 stages, `hold_o` rises at the falling edge that follows the third rising edge sampling `pd_n` low, and not earlier.
- R3: All bits of `hold_o` are always equal, and all bits of `vco_en_o` are always equal.
- R4: `osc_en_o` is low only while every bit of `hold_o` is 1. The clock outputs are parked before the oscillator stops.
- R5: The oscillator and VCOs are switched off in the cycle after `ref_low_i` is seen high while waiting for the reference outputs. While `ref_low_i` stays 0, they stay on indefinitely.
- R6: While the synchronized request persists in shutdown, `osc_en_o` and `vco_en_o` are all 0.
- R7: A request that is withdrawn during entry still completes entry: `osc_en_o` goes low for at least one cycle before wake-up starts.
- R8: On wake, `osc_en_o` rises one cycle before `vco_en_o`. `vco_en_o` is never high while `osc_en_o` is low.
- R9: `hold_o` falls `SETTLE_CYC` cycles after `vco_en_o` rises.
- R10: The time from `osc_en_o` rising to `hold_o` falling stays below 3 ms at a sequencer clock of `REF_KHZ` kHz.
- R11: A request that reappears during wake-up does not cut it short. `hold_o` still falls, stays low for two cycles, and entry then starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| ref_low_i | input | 1 | High when the reference clock outputs are parked low |
| hold_o | output | N_GRP | Per-group output hold, 1 parks that group low |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | N_VCO | VCO enables |

## Verification
A state machine stuck in the wrong state or taking a wrong branch shows up at the ports within a few cycles of the request edge:

- The hold controls rise a cycle early or late.
- The oscillator turns off while the hold is still low or before the reference-low report.
- The VCOs come up together with the oscillator instead of one cycle later.

A settle counter of the wrong length moves the hold release away from its exact cycle. A sequencer that drops an entry cut short by the request will never show the oscillator low. The bench checks each of these edges against the cycle computed from the synchronizer depth and settle length.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_PARK_OUTPUTS,
        ST_WAIT_REF_LOW,
        ST_SHUTDOWN,
        ST_WAKE_OSC,
        ST_SETTLE,
        ST_RELEASE
    } pd_state_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_settle_cnt.sv
module pwrdn_settle_cnt #(
    parameter int SETTLE_CYC = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!en) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);
endmodule

// File: rtl/pwrdn_hold_park.sv
module pwrdn_hold_park #(
    parameter int N_GRP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    output logic [N_GRP-1:0] hold
);
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            logic hold_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) hold_q <= 1'b0;
                else        hold_q <= park;
            end
            assign hold[g] = hold_q;
        end
    endgenerate
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
    parameter int N_GRP       = 4,
    parameter int N_VCO       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 2048,
    parameter int REF_KHZ     = 14318
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             ref_low_i,
    output logic [N_GRP-1:0] hold_o,
    output logic             osc_en_o,
    output logic [N_VCO-1:0] vco_en_o
);
    import pwrdn_pkg::*;

    localparam int WAKE_LIMIT = REF_KHZ * 3;

    pd_state_e state_q, state_d;
    logic      pd_n_sync;
    logic      req;
    logic      settle_done;
    logic      park;
    logic      osc_on;
    logic      vco_on;

    pwrdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_n_sync)
    );

    assign req = ~pd_n_sync;

    pwrdn_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:          if (req) state_d = ST_PARK_OUTPUTS;
            ST_PARK_OUTPUTS: state_d = ST_WAIT_REF_LOW;
            ST_WAIT_REF_LOW: if (ref_low_i) state_d = ST_SHUTDOWN;
            ST_SHUTDOWN:     if (!req) state_d = ST_WAKE_OSC;
            ST_WAKE_OSC:     state_d = ST_SETTLE;
            ST_SETTLE:       if (settle_done) state_d = ST_RELEASE;
            ST_RELEASE:      state_d = ST_RUN;
            default:         state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        park   = 1'b1;
        osc_on = 1'b1;
        vco_on = 1'b1;
        unique case (state_q)
            ST_RUN:          park = 1'b0;
            ST_PARK_OUTPUTS: ;
            ST_WAIT_REF_LOW: ;
            ST_SHUTDOWN:     begin osc_on = 1'b0; vco_on = 1'b0; end
            ST_WAKE_OSC:     vco_on = 1'b0;
            ST_SETTLE:       ;
            ST_RELEASE:      park = 1'b0;
            default:         park = 1'b0;
        endcase
    end

    pwrdn_hold_park #(.N_GRP(N_GRP)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .park  (park),
        .hold  (hold_o)
    );

    assign osc_en_o = osc_on;
    assign vco_en_o = {N_VCO{vco_on}};
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
    parameter int N_GRP      = 4,
    parameter int N_VCO      = 2,
    parameter int WAKE_LIMIT = 42954
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_low_i,
    input logic [N_GRP-1:0] hold_o,
    input logic             osc_en_o,
    input logic [N_VCO-1:0] vco_en_o
);
    logic        osc_prev;
    logic        waking;
    logic [31:0] wake_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_prev <= 1'b1;
            waking   <= 1'b0;
            wake_cnt <= '0;
        end else begin
            osc_prev <= osc_en_o;
            if (osc_en_o && !osc_prev) begin
                waking   <= 1'b1;
                wake_cnt <= '0;
            end else if (waking) begin
                if (hold_o == '0) waking <= 1'b0;
                else              wake_cnt <= wake_cnt + 1'b1;
            end
        end
    end

    AST_GROUPS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o == '0) || (&hold_o)); // R3
    AST_VCO_ALL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_en_o == '0) || (&vco_en_o)); // R3
    AST_PARK_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> (&hold_o)); // R4
    AST_REF_LOW_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> $past(ref_low_i)); // R5
    AST_VCO_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_en_o != '0) |-> osc_en_o); // R8
    AST_WAKE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        waking |-> (wake_cnt < 32'(WAKE_LIMIT))); // R10
endmodule

bind pwrdn_seq pwrdn_seq_chk #(
    .N_GRP(N_GRP), .N_VCO(N_VCO), .WAKE_LIMIT(WAKE_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_low_i(ref_low_i),
    .hold_o(hold_o), .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
);

// File: tb/pwrdn_seq_tb.sv
module pwrdn_seq_tb;
    localparam int NG = 4;
    localparam int NV = 2;
    localparam int SS = 2;
    localparam int SC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_n = 1'b1;
    logic          ref_low_i = 1'b1;
    logic [NG-1:0] hold_o;
    logic          osc_en_o;
    logic [NV-1:0] vco_en_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  ref_auto = 1'b0;
    int  ref_delay = 0;
    int  ref_cnt = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pwrdn_seq #(.N_GRP(NG), .N_VCO(NV), .SYNC_STAGES(SS),
                .SETTLE_CYC(SC), .REF_KHZ(14318)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ref_low_i(ref_low_i),
        .hold_o(hold_o), .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
    );

    function automatic int park_ticks();   return SS + 1;      endfunction
    function automatic int off_ticks();    return SS + 3;      endfunction
    function automatic int osc_on_ticks(); return SS + 1;      endfunction
    function automatic int vco_on_ticks(); return SS + 2;      endfunction
    function automatic int release_ticks(); return SS + 2 + SC; endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #3;
        if (ref_auto) begin
            if (&hold_o) begin
                ref_cnt++;
                ref_low_i = (ref_cnt > ref_delay);
            end else begin
                ref_cnt   = 0;
                ref_low_i = 1'b0;
            end
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #400000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        ticks(2);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(hold_o == '0, "R1", int'(hold_o), 0);
        chk(osc_en_o == 1'b1, "R1", int'(osc_en_o), 1);
        chk(vco_en_o == '1, "R1", int'(vco_en_o), 3);

        // R2 synchronizer latency and R3 grouping
        pd_n = 1'b0;
        ticks(park_ticks() - 1);
        chk(hold_o == '0, "R2", int'(hold_o), 0);
        tick();
        chk(hold_o == '1, "R2", int'(hold_o), 15);
        chk(osc_en_o == 1'b1, "R4", int'(osc_en_o), 1);
        ticks(off_ticks() - park_ticks() - 1);
        chk(osc_en_o == 1'b1, "R4", int'(osc_en_o), 1);
        tick();
        // R6 shutdown
        chk(osc_en_o == 1'b0, "R6", int'(osc_en_o), 0);
        chk(vco_en_o == '0, "R6", int'(vco_en_o), 0);
        ticks(5);
        chk(osc_en_o == 1'b0 && vco_en_o == '0, "R6", int'(osc_en_o), 0);

        // R8 wake order, R9 settle
        pd_n = 1'b1;
        ticks(osc_on_ticks());
        chk(osc_en_o == 1'b1, "R8", int'(osc_en_o), 1);
        chk(vco_en_o == '0, "R8", int'(vco_en_o), 0);
        tick();
        chk(vco_en_o == '1, "R8", int'(vco_en_o), 3);
        ticks(release_ticks() - vco_on_ticks() - 1);
        chk(hold_o == '1, "R9", int'(hold_o), 15);
        tick();
        chk(hold_o == '0, "R9", int'(hold_o), 0);
        ticks(3);

        // R5 wait for reference outputs
        ref_low_i = 1'b0;
        pd_n = 1'b0;
        ticks(off_ticks() + 10);
        chk(osc_en_o == 1'b1, "R5", int'(osc_en_o), 1);
        chk(hold_o == '1, "R5", int'(hold_o), 15);
        ref_low_i = 1'b1;
        tick();
        chk(osc_en_o == 1'b0, "R5", int'(osc_en_o), 0);
        pd_n = 1'b1;
        ticks(release_ticks() + 3);
        chk(hold_o == '0 && osc_en_o, "R5", int'(hold_o), 0);

        // R7 request withdrawn during entry
        pd_n = 1'b0;
        tick();
        pd_n = 1'b1;
        ticks(off_ticks() - 1);
        chk(osc_en_o == 1'b0, "R7", int'(osc_en_o), 0);
        tick();
        chk(osc_en_o == 1'b1, "R7", int'(osc_en_o), 1);
        ticks(release_ticks() + 3);
        chk(hold_o == '0, "R7", int'(hold_o), 0);

        // R11 request returns during settle
        pd_n = 1'b0;
        ticks(off_ticks() + 2);
        pd_n = 1'b1;
        ticks(vco_on_ticks());
        pd_n = 1'b0;
        ticks(release_ticks() - vco_on_ticks());
        chk(hold_o == '0, "R11", int'(hold_o), 0);
        tick();
        chk(hold_o == '0, "R11", int'(hold_o), 0);
        tick();
        chk(hold_o == '1, "R11", int'(hold_o), 15);
        pd_n = 1'b1;
        ticks(40);

        // random episodes with modelled reference parking
        ref_auto = 1'b1;
        for (int ep = 0; ep < 40; ep++) begin
            bit saw_off = 1'b0;
            bit back = 1'b0;
            int low_len = 1 + int'($urandom_range(0, 19));
            ref_delay = int'($urandom_range(0, 4));
            pd_n = 1'b0;
            for (int c = 0; c < low_len; c++) begin
                tick();
                if (!osc_en_o) saw_off = 1'b1;
                chk(osc_en_o || (&hold_o), "R4", int'(hold_o), 15);
                chk(!(vco_en_o != '0 && !osc_en_o), "R8", int'(vco_en_o), 0);
            end
            pd_n = 1'b1;
            for (int c = 0; c < 60 && !back; c++) begin
                tick();
                if (!osc_en_o) saw_off = 1'b1;
                chk(osc_en_o || (&hold_o), "R4", int'(hold_o), 15);
                chk(hold_o == '0 || (&hold_o), "R3", int'(hold_o), 15);
                if (saw_off && osc_en_o && hold_o == '0) back = 1'b1;
            end
            chk(saw_off, "R7", int'(saw_off), 1);
            chk(back, "R10", int'(back), 1);
            ticks(int'($urandom_range(1, 5)));
        end
        ref_auto = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule